// File: doc/BRIEF.md
# Oscillation Stabilization Status Counter

This block measures how long an external crystal oscillator has been running since it was last started. After the oscillator is enabled, or after a low-power stop state ends, a counter in the crystal-clock domain counts real crystal edges. It turns progress into an 8-bit status word that fills from the top bit down. Each bit switches on at a fixed power-of-two edge count, and the spacing between thresholds is uneven. Software polls the word on the bus clock to decide when the crystal can safely drive the core.

A 3-bit selection input sets how far the counter goes. The counter stops at the selected threshold, so status bits with larger thresholds stay at zero. A done flag reports that the selected threshold has been reached. The status word is cleared by reset, while the stop state is requested, and while the oscillator is switched off. Counting starts again from zero when the clear is released.

Top module: `osc_stab_status`

## Requirements
- R1: With default exponents, status bit 7 sets after 2^8 crystal edges, bit 6 after 2^9, bit 5 after 2^10, bit 4 after 2^11, bit 3 after 2^13, bit 2 after 2^15, bit 1 after 2^17 and bit 0 after 2^18, counted from the release of the clear. A bit is never set before its edge count has elapsed. The exponents are a parameter (one 5-bit value per status bit) and must increase from bit 7 to bit 0.
- R2: The status word is always of the form ones-then-zeros from bit 7 downward. Bits are added one at a time in the order 7, 6, …, 0.
- R3: Once a status bit is set, it stays set until a clear.
- R4: A select value s (0 to 7) caps the count at the threshold of status bit 7-s. Every bit below 7-s stays 0, so the final word has its top s+1 bits set.
- R5: `done` is 1 exactly when status bit 7-s is set, where s is the select value.
- R6: A low level on `rst_n` clears the status word and `done` to 0 at once, without waiting for a clock edge.
- R7: While `stop_req` is 1, the status word and `done` are 0 at once. After `stop_req` returns to 0, the count restarts from zero.
- R8: While `osc_off` is 1, the status word and `done` are 0 at once. After `osc_off` returns to 0, the count restarts from zero.
- R9: Only edges on `xclk` advance the count. If the crystal clock does not toggle, the status word stays 0 however many bus cycles pass.
- R10: Outside a clear, the status word seen on the bus clock changes by at most one bit between consecutive bus-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xclk | input | 1 | Crystal clock whose edges are counted |
| bclk | input | 1 | Bus clock; status is presented in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, from any reset source |
| stop_req | input | 1 | Stop state requested; level-sensitive clear |
| osc_off | input | 1 | Oscillator switched off; level-sensitive clear |
| sel | input | 3 | Stabilization-limit select, 0 to 7 |
| status | output | 8 | Thermometer-coded progress word, bus-clock domain |
| done | output | 1 | Selected threshold reached |

## Verification
The properties assume that `sel` is changed only while a clear is active. They also assume that consecutive thresholds are far enough apart in crystal edges that the bus clock sees each new bit on its own. The stimulus therefore writes each selection, random or directed, while `osc_off` is held high and then releases it. The crystal and bus clocks run at fixed, unrelated periods, and scaled-down exponents keep the full spacing ratios. Clears are driven between bus edges, and their immediate effect is sampled just after.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int unsigned NB   = 8;
  localparam int unsigned SELW = 3;
  localparam int unsigned EW   = 5;
  typedef logic [NB-1:0]         stat_t;
  typedef logic [NB-1:0][EW-1:0] exp_list_t;
  localparam exp_list_t EXP_DEFAULT =
    {5'd8, 5'd9, 5'd10, 5'd11, 5'd13, 5'd15, 5'd17, 5'd18};
endpackage

// File: rtl/osc_clr_sync.sv
module osc_clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q, chain_nxt;

  always_comb chain_nxt = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/osc_stab_cnt.sv
module osc_stab_cnt
  import osc_stab_pkg::*;
#(
  parameter exp_list_t EXP_LIST = EXP_DEFAULT
) (
  input  logic            xclk,
  input  logic            xrst_n,
  input  logic [SELW-1:0] sel,
  output stat_t           therm
);
  localparam int unsigned CW = int'(EXP_LIST[0]) + 1;

  logic [CW-1:0]   cnt_q, cnt_nxt, limit;
  logic            cnt_en;
  logic [SELW-1:0] lim_idx;
  stat_t           therm_q, therm_nxt;

  always_comb begin
    lim_idx = SELW'(NB - 1) - sel;
    limit   = CW'(1) << EXP_LIST[lim_idx];
    cnt_en  = (cnt_q < limit);
    cnt_nxt = cnt_en ? cnt_q + CW'(1) : cnt_q;
  end

  for (genvar i = 0; i < NB; i++) begin : g_thr
    always_comb therm_nxt[i] = (cnt_q >= (CW'(1) << EXP_LIST[i]));
  end

  always_ff @(posedge xclk or negedge xrst_n) begin
    if (!xrst_n) begin
      cnt_q   <= '0;
      therm_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_nxt;
      therm_q <= therm_nxt;
    end
  end

  assign therm = therm_q;

  // R4: the count never passes the selected limit
  p_cap_r4: assert property (@(posedge xclk) disable iff (!xrst_n)
    cnt_q <= limit);
  // R3: set bits are sticky in the crystal domain
  p_sticky_r3: assert property (@(posedge xclk) disable iff (!xrst_n)
    (therm_q & $past(therm_q)) == $past(therm_q));
  // R2: filled from bit 7 downward, no gaps
  p_shape_r2: assert property (@(posedge xclk) disable iff (!xrst_n)
    ((therm_q << 1) & ~therm_q) == '0);
endmodule

// File: rtl/osc_status_sync.sv
module osc_status_sync
  import osc_stab_pkg::*;
(
  input  logic  bclk,
  input  logic  arst_n,
  input  stat_t din,
  output stat_t dout
);
  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic [1:0] s_q, s_nxt;
    always_comb s_nxt = {s_q[0], din[i]};
    always_ff @(posedge bclk or negedge arst_n) begin
      if (!arst_n) s_q <= '0;
      else         s_q <= s_nxt;
    end
    assign dout[i] = s_q[1];
  end

  // R10: one bit per bus edge at most
  p_one_step_r10: assert property (@(posedge bclk) disable iff (!arst_n)
    $countones(dout ^ $past(dout)) <= 1);
endmodule

// File: rtl/osc_stab_status.sv
module osc_stab_status
  import osc_stab_pkg::*;
#(
  parameter exp_list_t EXP_LIST = EXP_DEFAULT
) (
  input  logic            xclk,
  input  logic            bclk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic            osc_off,
  input  logic [SELW-1:0] sel,
  output logic [NB-1:0]   status,
  output logic            done
);
  logic            clr_n;
  logic            xrst_n;
  stat_t           therm_x;
  logic [SELW-1:0] done_idx;

  assign clr_n = rst_n & ~stop_req & ~osc_off;

  osc_clr_sync #(.STAGES(2)) u_clr_sync (
    .clk    (xclk),
    .arst_n (clr_n),
    .srst_n (xrst_n)
  );

  osc_stab_cnt #(.EXP_LIST(EXP_LIST)) u_cnt (
    .xclk   (xclk),
    .xrst_n (xrst_n),
    .sel    (sel),
    .therm  (therm_x)
  );

  osc_status_sync u_sync (
    .bclk   (bclk),
    .arst_n (clr_n),
    .din    (therm_x),
    .dout   (status)
  );

  always_comb begin
    done_idx = SELW'(NB - 1) - sel;
    done     = status[done_idx];
  end

  // R7 / R8: a held clear keeps the outputs at zero
  p_clr_hold_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    (stop_req || osc_off) |-> (status == '0 && !done));
  // R5: done implies the first threshold has been seen
  p_done_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    done |-> status[NB-1]);
endmodule

// File: tb/osc_stab_status_bench.sv
module osc_stab_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XHALF      = 4;
  localparam int MARGIN     = 12;
  localparam logic [7:0][4:0] EXPL =
    {5'd4, 5'd5, 5'd6, 5'd7, 5'd9, 5'd11, 5'd13, 5'd14};

  logic       xclk = 1'b0, bclk = 1'b0, xrun = 1'b1;
  logic       rst_n = 1'b0, stop_req = 1'b0, osc_off = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] status;
  logic       done;
  logic       clr_b;
  int         x_edges;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  osc_stab_status #(.EXP_LIST(EXPL)) u_osc_stab_status (
    .xclk(xclk), .bclk(bclk), .rst_n(rst_n), .stop_req(stop_req),
    .osc_off(osc_off), .sel(sel), .status(status), .done(done)
  );

  initial forever #(CLK_PERIOD/2) bclk = ~bclk;
  initial forever begin #XHALF; if (xrun) xclk = ~xclk; end

  assign clr_b = rst_n & ~stop_req & ~osc_off;
  always @(posedge xclk or negedge clr_b)
    if (!clr_b) x_edges <= 0;
    else        x_edges <= x_edges + 1;

  function automatic int thr(int b);
    return 1 << int'(EXPL[b]);
  endfunction
  function automatic logic [7:0] thermo(int n);
    return ~(8'hFF >> n);
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_edges(int n);
    while (x_edges < n) @(negedge bclk);
  endtask

  task automatic restart(logic [2:0] s);
    @(negedge bclk); osc_off = 1'b1; sel = s;
    @(negedge bclk); osc_off = 1'b0;
  endtask

  // R1, R2, R4, R5 (R10 follows from the exact per-step words)
  task automatic run_trial(logic [2:0] s);
    restart(s);
    for (int k = 0; k < 8; k++) begin
      wait_edges(thr(7-k) - 1);
      chk("R1 early", {1'b0, status[7-k]}, 9'd0);
      if (k > int'(s)) begin
        wait_edges(thr(7-k) + MARGIN);
        chk("R4 capped", {done, status}, {1'b1, thermo(int'(s) + 1)});
        break;
      end
      wait_edges(thr(7-k) + MARGIN);
      chk("R2 shape", {1'b0, status}, {1'b0, thermo(k + 1)});
      chk("R5 done", {8'd0, done}, {8'd0, k == int'(s)});
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD*3 + 2);
    chk("R6 reset", {done, status}, 9'd0);
    rst_n = 1'b1;

    run_trial(3'd0);
    run_trial(3'd7);
    run_trial(3'd3);
    for (int t = 0; t < 3; t++) run_trial(3'($urandom_range(0, 5)));

    // R3: full word holds over many bus cycles
    restart(3'd2);
    wait_edges(thr(5) + MARGIN);
    for (int c = 0; c < 40; c++) begin
      @(negedge bclk);
      chk("R3 sticky", {done, status}, {1'b1, thermo(3)});
    end

    // R7: stop clears at once and restarts from zero
    @(negedge bclk); stop_req = 1'b1; #1;
    chk("R7 stop clear", {done, status}, 9'd0);
    repeat (5) @(negedge bclk);
    chk("R7 stop hold", {done, status}, 9'd0);
    stop_req = 1'b0;
    wait_edges(thr(7) - 1);
    chk("R7 restart", {1'b0, status}, 9'd0);
    wait_edges(thr(7) + MARGIN);
    chk("R7 recount", {1'b0, status}, {1'b0, thermo(1)});

    // R8: oscillator off clears at once
    wait_edges(thr(5) + MARGIN);
    @(negedge bclk); osc_off = 1'b1; #1;
    chk("R8 off clear", {done, status}, 9'd0);
    @(negedge bclk); osc_off = 1'b0;
    wait_edges(thr(7) - 1);
    chk("R8 restart", {1'b0, status}, 9'd0);

    // R6: reset mid-count
    wait_edges(thr(6) + MARGIN);
    @(negedge bclk); rst_n = 1'b0; #1;
    chk("R6 async reset", {done, status}, 9'd0);
    @(negedge bclk); rst_n = 1'b1;

    // R9: no crystal edges, no progress
    @(negedge bclk); osc_off = 1'b1; xrun = 1'b0; sel = 3'd1;
    @(negedge bclk); osc_off = 1'b0;
    repeat (300) @(negedge bclk);
    chk("R9 idle xclk", {done, status}, 9'd0);
    xrun = 1'b1;
    wait_edges(thr(6) + MARGIN);
    chk("R9 resumed", {done, status}, {1'b1, thermo(2)});

    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*190000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule